// File: doc/BRIEF.md
# Packet Slot FIFO

This block buffers whole packets instead of single words. It holds up to three packets of at most 32 bytes each, for the transmit or receive path of a short-range radio link. A producer streams bytes into the slot being filled and then strobes a commit. The commit stores the packet length with the slot and hands the slot to the consumer.

The consumer reads the head packet one byte at a time, starting at byte 0. It can query the stored length of the head packet at any time, and it frees the slot with a pop. There are three control inputs:
- A flush input empties the whole buffer in one cycle, including any packet that is only partly written.
- A reuse input keeps the head packet in place across pops, so that the same packet can be sent again.
- The flag outputs, including a sticky overflow flag, also appear together in a small status byte.

Top module: `pkt_slot_fifo`

## Requirements
- R1: After reset the FIFO is empty and not full, overflow is 0, `head_len` is 0, `rd_data` is 0x00 and `status` is 0x02.
- R2: Each byte written with `wr_valid` is stored at the next position of the slot being filled. A `wr_commit` (which may come in the same cycle as the last byte) stores the byte count with the slot. While the FIFO is not empty, `head_len` reports the stored length of the head packet, and `rd_data` shows the head byte at the current read position. The read position starts at 0, and each `rd_next` advances it by one.
- R3: There are exactly three slots. `full` is 1 while all three are occupied, and `empty` is 1 while none is occupied. `status` bit 0 is full, bit 1 is empty, bit 2 is overflow, and bits 7:3 are 0.
- R4: Bytes written beyond the 32nd byte of a packet are discarded. The committed length saturates at 32, and `head_len` never exceeds 32.
- R5: A byte write or a commit attempted while the FIFO is full has no effect on the stored packets. It sets `overflow`, which stays set until a flush.
- R6: When the read position is at or beyond the head packet's length, `rd_data` is 0x00. It is also 0x00 while the FIFO is empty, and `head_len` is then 0.
- R7: `rd_pop` frees the head slot and returns the read position to 0. Packets come out in commit order, including across slot wrap-around. A pop on an empty FIFO is ignored.
- R8: `flush` empties every slot in one cycle. It discards a partly written packet and clears `overflow` and reuse mode. Flush takes priority over every other input in the same cycle.
- R9: A `reuse` strobe with a packet present turns reuse mode on. While reuse mode is on, `rd_pop` only returns the read position to 0 and leaves the head packet stored. A flush or an accepted commit turns reuse mode off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty all slots and discard a partial packet |
| reuse | input | 1 | Keep the head packet across pops |
| wr_valid | input | 1 | Write `wr_data` into the slot being filled |
| wr_data | input | 8 | Byte to write |
| wr_commit | input | 1 | Close the packet being filled |
| rd_next | input | 1 | Advance the read position of the head packet |
| rd_pop | input | 1 | Release the head packet |
| rd_data | output | 8 | Head packet byte at the read position, or 0x00 |
| head_len | output | 6 | Byte count of the head packet, 0 when empty |
| full | output | 1 | All three slots occupied |
| empty | output | 1 | No slot occupied |
| overflow | output | 1 | Sticky: write or commit attempted while full |
| status | output | 8 | {5'b0, overflow, empty, full} |

## Verification
The assertions check on every cycle the properties that hold regardless of stored contents:
- `full` and `empty` are never both set.
- The reported length stays within 32.
- `rd_data` is 0x00 whenever the FIFO is empty.
- Overflow is raised by any write or commit attempted when full, and it stays set until a flush.
- A flush leaves the FIFO empty on the next cycle.

Only the directed scenarios can show the behaviours that depend on contents and sequence:
- byte order within a packet and packet order across wrap-around;
- truncation at 32 bytes;
- loss of a partial packet on flush;
- reuse mode holding the head packet through pops until a commit ends it.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
    localparam int unsigned DEF_SLOTS = 3;
    localparam int unsigned DEF_BYTES = 32;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store
    import pkt_fifo_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned BYTES = DEF_BYTES,
    localparam int unsigned PW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int unsigned IW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] wslot,
    input  logic [IW-1:0] widx,
    input  byte_t         wdata,
    input  logic [PW-1:0] rslot,
    input  logic [IW-1:0] ridx,
    output byte_t         rdata
);
    byte_t [SLOTS-1:0] slot_byte;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        byte_t [BYTES-1:0] mem_q;
        always_ff @(posedge clk) begin
            if (we && (wslot == PW'(s))) begin
                mem_q[widx] <= wdata;
            end
        end
        assign slot_byte[s] = mem_q[ridx];
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (rslot == PW'(s)) begin
                rdata = slot_byte[s];
            end
        end
    end
endmodule

// File: rtl/pkt_fifo_ctrl.sv
module pkt_fifo_ctrl
    import pkt_fifo_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned BYTES = DEF_BYTES,
    localparam int unsigned PW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int unsigned IW = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int unsigned LW = $clog2(BYTES + 1),
    localparam int unsigned CW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          reuse,
    input  logic          wr_valid,
    input  logic          wr_commit,
    input  logic          rd_next,
    input  logic          rd_pop,
    output logic          mem_we,
    output logic [PW-1:0] mem_wslot,
    output logic [IW-1:0] mem_widx,
    output logic [PW-1:0] mem_rslot,
    output logic [IW-1:0] mem_ridx,
    output logic          rd_valid,
    output logic [LW-1:0] head_len,
    output logic          full,
    output logic          empty,
    output logic          overflow
);
    typedef struct packed {
        logic [SLOTS-1:0][LW-1:0] len;
        logic [PW-1:0]            wr_ptr;
        logic [PW-1:0]            rd_ptr;
        logic [CW-1:0]            cnt;
        logic [LW-1:0]            wr_cnt;
        logic [LW-1:0]            rd_idx;
        logic                     reuse_on;
        logic                     ovf;
    } state_t;

    state_t q, d;
    logic   write_ok, commit_ok, pop_ok, free_ok;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full  = (q.cnt == CW'(SLOTS));
    assign empty = (q.cnt == '0);

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        write_ok  = wr_valid && !full;
        commit_ok = wr_commit && !full;
        pop_ok    = rd_pop && !empty;
        free_ok   = pop_ok && !q.reuse_on;

        if (write_ok && (q.wr_cnt < LW'(BYTES))) begin
            mem_we   = 1'b1;
            d.wr_cnt = q.wr_cnt + LW'(1);
        end
        if ((wr_valid || wr_commit) && full) begin
            d.ovf = 1'b1;
        end
        if (reuse && !empty) begin
            d.reuse_on = 1'b1;
        end
        if (pop_ok) begin
            d.rd_idx = '0;
            if (!q.reuse_on) begin
                d.rd_ptr = step_ptr(q.rd_ptr);
            end
        end else if (rd_next && !empty && (q.rd_idx < LW'(BYTES))) begin
            d.rd_idx = q.rd_idx + LW'(1);
        end
        if (commit_ok) begin
            d.len[q.wr_ptr] = d.wr_cnt;
            d.wr_ptr        = step_ptr(q.wr_ptr);
            d.wr_cnt        = '0;
            d.reuse_on      = 1'b0;
        end
        d.cnt = q.cnt + CW'(commit_ok) - CW'(free_ok);

        if (flush) begin
            mem_we     = 1'b0;
            d.wr_ptr   = '0;
            d.rd_ptr   = '0;
            d.cnt      = '0;
            d.wr_cnt   = '0;
            d.rd_idx   = '0;
            d.reuse_on = 1'b0;
            d.ovf      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_wslot = q.wr_ptr;
    assign mem_widx  = q.wr_cnt[IW-1:0];
    assign mem_rslot = q.rd_ptr;
    assign mem_ridx  = q.rd_idx[IW-1:0];
    assign head_len  = empty ? '0 : q.len[q.rd_ptr];
    assign rd_valid  = !empty && (q.rd_idx < head_len);
    assign overflow  = q.ovf;
endmodule

// File: rtl/pkt_slot_fifo.sv
module pkt_slot_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned BYTES = DEF_BYTES,
    localparam int unsigned PW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int unsigned IW = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int unsigned LW = $clog2(BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          reuse,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          wr_commit,
    input  logic          rd_next,
    input  logic          rd_pop,
    output logic [7:0]    rd_data,
    output logic [LW-1:0] head_len,
    output logic          full,
    output logic          empty,
    output logic          overflow,
    output logic [7:0]    status
);
    logic          mem_we, rd_valid;
    logic [PW-1:0] mem_wslot, mem_rslot;
    logic [IW-1:0] mem_widx, mem_ridx;
    byte_t         mem_rdata;

    pkt_fifo_ctrl #(.SLOTS(SLOTS), .BYTES(BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .reuse(reuse),
        .wr_valid(wr_valid), .wr_commit(wr_commit),
        .rd_next(rd_next), .rd_pop(rd_pop),
        .mem_we(mem_we), .mem_wslot(mem_wslot), .mem_widx(mem_widx),
        .mem_rslot(mem_rslot), .mem_ridx(mem_ridx),
        .rd_valid(rd_valid), .head_len(head_len),
        .full(full), .empty(empty), .overflow(overflow)
    );

    pkt_fifo_store #(.SLOTS(SLOTS), .BYTES(BYTES)) u_store (
        .clk(clk), .we(mem_we), .wslot(mem_wslot), .widx(mem_widx),
        .wdata(wr_data), .rslot(mem_rslot), .ridx(mem_ridx),
        .rdata(mem_rdata)
    );

    assign rd_data = rd_valid ? mem_rdata : 8'h00;
    assign status  = {5'b0, overflow, empty, full};
endmodule

// File: rtl/pkt_fifo_chk.sv
module pkt_fifo_chk #(
    parameter int unsigned BYTES = 32,
    localparam int unsigned LW = $clog2(BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          wr_valid,
    input logic          wr_commit,
    input logic [7:0]    rd_data,
    input logic [LW-1:0] head_len,
    input logic          full,
    input logic          empty,
    input logic          overflow
);
    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    // R4
    len_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_len <= LW'(BYTES));
    // R6
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rd_data == 8'h00 && head_len == '0));
    // R5
    ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_valid || wr_commit) && full && !flush) |=> overflow);
    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);
    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !overflow));
endmodule

bind pkt_slot_fifo pkt_fifo_chk #(.BYTES(BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid),
    .wr_commit(wr_commit), .rd_data(rd_data), .head_len(head_len),
    .full(full), .empty(empty), .overflow(overflow)
);

// File: tb/pkt_slot_fifo_test.sv
module pkt_slot_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 0, reuse = 0, wr_valid = 0, wr_commit = 0, rd_next = 0, rd_pop = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [5:0] head_len;
    logic       full, empty, overflow;
    logic [7:0] status;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    pkt_slot_fifo uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .reuse(reuse),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_commit(wr_commit),
        .rd_next(rd_next), .rd_pop(rd_pop), .rd_data(rd_data),
        .head_len(head_len), .full(full), .empty(empty),
        .overflow(overflow), .status(status)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FIFO FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        flush = 0; reuse = 0; wr_valid = 0; wr_commit = 0; rd_next = 0; rd_pop = 0;
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed + 3 * i);
    endfunction

    task automatic push_pkt(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1; wr_data = pat(seed, i);
            if (i == n - 1) wr_commit = 1;
            cyc();
        end
        if (n == 0) begin
            wr_commit = 1; cyc();
        end
    endtask

    task automatic read_pkt(input string req, input int n, input int seed);
        check({req, " len"}, head_len, n);
        for (int i = 0; i < n; i++) begin
            check({req, " byte"}, rd_data, pat(seed, i));
            rd_next = 1; cyc();
        end
    endtask

    task automatic t_reset();
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 overflow", overflow, 0);
        check("R1 head_len", head_len, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 status", status, 8'h02);
    endtask

    task automatic t_basic();
        push_pkt(5, 8'h10);
        check("R2 empty", empty, 0);
        read_pkt("R2", 5, 8'h10);
        check("R6 past end", rd_data, 0);
        rd_next = 1; cyc();
        check("R6 past end again", rd_data, 0);
        rd_pop = 1; cyc();
        check("R7 empty after pop", empty, 1);
        check("R6 empty data", rd_data, 0);
        rd_pop = 1; cyc();
        check("R7 pop on empty ignored", empty, 1);
    endtask

    task automatic t_full();
        push_pkt(1, 8'h20);
        push_pkt(32, 8'h40);
        push_pkt(7, 8'h80);
        check("R3 full", full, 1);
        check("R3 status", status, 8'h01);
        wr_valid = 1; wr_data = 8'hEE; cyc();
        check("R5 overflow on write", overflow, 1);
        wr_commit = 1; cyc();
        check("R3 status ovf", status, 8'h05);
        check("R5 head kept", head_len, 1);
        read_pkt("R7 first", 1, 8'h20);
        rd_pop = 1; cyc();
        check("R3 not full", full, 0);
        push_pkt(3, 8'h33);
        read_pkt("R7 second", 32, 8'h40);
        rd_pop = 1; cyc();
        read_pkt("R7 third", 7, 8'h80);
        rd_pop = 1; cyc();
        read_pkt("R7 wrapped", 3, 8'h33);
        rd_pop = 1; cyc();
        check("R7 empty", empty, 1);
        check("R5 sticky", overflow, 1);
        flush = 1; cyc();
        check("R8 overflow cleared", overflow, 0);
    endtask

    task automatic t_sat();
        push_pkt(40, 8'h05);
        check("R4 saturated len", head_len, 32);
        read_pkt("R4", 32, 8'h05);
        check("R4 no extra byte", rd_data, 0);
        rd_pop = 1; cyc();
    endtask

    task automatic t_flush();
        push_pkt(2, 8'h60);
        for (int i = 0; i < 3; i++) begin
            wr_valid = 1; wr_data = 8'hA0; cyc();
        end
        flush = 1; wr_commit = 1; cyc();
        check("R8 flushed empty", empty, 1);
        check("R8 flushed len", head_len, 0);
        push_pkt(2, 8'h70);
        read_pkt("R8 partial dropped", 2, 8'h70);
        rd_pop = 1; cyc();
    endtask

    task automatic t_reuse();
        push_pkt(4, 8'h11);
        push_pkt(2, 8'h90);
        reuse = 1; cyc();
        rd_next = 1; cyc();
        rd_pop = 1; cyc();
        read_pkt("R9 kept after pop", 4, 8'h11);
        rd_pop = 1; cyc();
        check("R9 kept twice", head_len, 4);
        push_pkt(1, 8'h55);
        rd_pop = 1; cyc();
        read_pkt("R9 reuse ended by commit", 2, 8'h90);
        reuse = 1; cyc();
        flush = 1; cyc();
        push_pkt(3, 8'h22);
        rd_pop = 1; cyc();
        check("R9 reuse ended by flush", empty, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        t_reset();
        t_basic();
        t_full();
        t_sat();
        t_flush();
        t_reuse();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FIFO FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule